// File: doc/BRIEF.md
# Oldest-First Issue Queue with Tag Wakeup

This block is the scheduling window between dispatch and execution in an out-of-order core. Instructions come in as bundles of up to WIDTH. Each instruction carries a sequence number and two source operands. Each operand has a producer tag and a flag that says whether its value already exists. Completion ports broadcast the tags of finished producers, and any queued operand waiting on a broadcast tag becomes ready. Each cycle, the oldest instructions whose operands are both ready are offered on the issue lanes.

The dispatch side is a valid/ready stream. A bundle transfers on a cycle where `disp_valid` and `disp_ready` are both high. `disp_ready` drops whenever the free entries cannot hold the whole bundle, and the sender must then hold the bundle stable. The issue side is also a valid/ready stream. The lanes are packed, with lane 0 holding the oldest instruction. When `iss_ready` is high, every presented lane transfers at once. When it is low, nothing leaves.

Sequence numbers wrap. The entries held at one time must span fewer than 2^(SEQ_W-1) numbers. Functional units, latencies and operand values are outside this block.

Top module: `iq_oldest_first`

## Requirements
- R1: After reset the queue is empty: `free_slots` equals IQ_SIZE and no `iss_valid` bit is set.
- R2: `disp_ready` is high exactly when `disp_cnt` is at most WIDTH and at most `free_slots`. An accepted bundle stores lanes 0 to `disp_cnt`-1 together. A refused bundle stores none of its lanes.
- R3: `free_slots` is the current number of empty entries. From one cycle to the next it falls by the accepted bundle size and rises by the number of lanes that transferred on issue.
- R4: An entry is offered on an issue lane only when both of its operand-ready flags are set.
- R5: Up to WIDTH eligible entries are offered per cycle, in ascending sequence order. Lane 0 holds the oldest, the valid lanes are contiguous from lane 0, and an eligible entry is skipped only when WIDTH older eligible entries exist.
- R6: Sequence a is older than b when bit SEQ_W-1 of (a - b) mod 2^SEQ_W is set. For example, with SEQ_W=5, 30 and 31 are both older than 0 and 1.
- R7: A valid broadcast on any completion port sets every queued operand flag whose tag equals the broadcast tag. The entry can be offered from the following cycle, not in the cycle of the broadcast.
- R8: A broadcast in the same cycle as the dispatch of an operand with a matching tag marks that incoming operand ready.
- R9: While `iss_ready` is low, offered entries stay queued and at least one lane stays valid. When it is high, all offered entries leave at the clock edge.
- R10: An entry freed by issue can receive a new instruction from the next cycle. New instructions may land in any freed entry, and their position never affects issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| disp_valid | input | 1 | A dispatch bundle is presented |
| disp_ready | output | 1 | Bundle fits and will be taken |
| disp_cnt | input | $clog2(WIDTH+1) | Number of used lanes in the bundle |
| disp_seq | input | WIDTH*SEQ_W | Sequence number per lane, lane 0 in the low bits |
| disp_tag_a | input | WIDTH*TAG_W | First operand producer tag per lane |
| disp_rdy_a | input | WIDTH | First operand already ready per lane |
| disp_tag_b | input | WIDTH*TAG_W | Second operand producer tag per lane |
| disp_rdy_b | input | WIDTH | Second operand already ready per lane |
| wk_valid | input | WK_PORTS | Completion broadcast valid per port |
| wk_tag | input | WK_PORTS*TAG_W | Completion broadcast tag per port |
| iss_ready | input | 1 | Downstream accepts all offered lanes |
| iss_valid | output | WIDTH | Lane carries an issuing instruction |
| iss_seq | output | WIDTH*SEQ_W | Sequence number per issue lane |
| free_slots | output | $clog2(IQ_SIZE+1) | Count of empty entries |

## Verification
An entry left valid or dropped by mistake shows up in `free_slots` in the next cycle. The same fault shows on `disp_ready` as soon as a bundle is offered near the full boundary. A ready flag that is stuck or set too early is visible on the issue lanes one cycle after the broadcast. There, a waiting instruction either appears before it should or never appears. A wrong age comparison, or selection by entry position, shows up as lane order once new instructions land in low entries that older instructions vacated. The bench forces that condition on purpose, and repeats it across the sequence wrap.

// File: rtl/iq_pkg.sv
package iq_pkg;

  // Age compare on a wrapping counter: a is older than b when the
  // modular difference a-b, taken over w bits, has its top bit set.
  function automatic logic seq_older(input logic [31:0] a,
                                     input logic [31:0] b,
                                     input int unsigned w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction

endpackage

// File: rtl/iq_tag_match.sv
module iq_tag_match #(
  parameter int unsigned M        = 8,
  parameter int unsigned TAG_W    = 6,
  parameter int unsigned WK_PORTS = 2
) (
  input  logic [M*TAG_W-1:0]        tags,
  input  logic [WK_PORTS-1:0]       wk_valid,
  input  logic [WK_PORTS*TAG_W-1:0] wk_tag,
  output logic [M-1:0]              hit
);

  for (genvar m = 0; m < M; m++) begin : g_ent
    always_comb begin
      hit[m] = 1'b0;
      for (int p = 0; p < WK_PORTS; p++) begin
        if (wk_valid[p] && (tags[m*TAG_W +: TAG_W] == wk_tag[p*TAG_W +: TAG_W]))
          hit[m] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/iq_select.sv
module iq_select
  import iq_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned WIDTH = 2,
  parameter int unsigned SEQ_W = 5,
  localparam int unsigned IDX_W  = $clog2(N),
  localparam int unsigned RANK_W = $clog2(N + 1)
) (
  input  logic [N-1:0]           elig,
  input  logic [N*SEQ_W-1:0]     seqs,
  output logic [N-1:0]           grant,
  output logic [WIDTH-1:0]       lane_valid,
  output logic [WIDTH*IDX_W-1:0] lane_idx
);

  logic [RANK_W-1:0] rank [N];

  // rank = number of eligible entries older than this one
  always_comb begin
    for (int i = 0; i < N; i++) begin
      rank[i] = '0;
      for (int j = 0; j < N; j++) begin
        if (j != i && elig[j] &&
            seq_older(32'(seqs[j*SEQ_W +: SEQ_W]), 32'(seqs[i*SEQ_W +: SEQ_W]), SEQ_W))
          rank[i] = rank[i] + RANK_W'(1);
      end
      grant[i] = elig[i] && (32'(rank[i]) < WIDTH);
    end
  end

  for (genvar k = 0; k < WIDTH; k++) begin : g_lane
    always_comb begin
      lane_valid[k]                 = 1'b0;
      lane_idx[k*IDX_W +: IDX_W]    = '0;
      for (int i = 0; i < N; i++) begin
        if (grant[i] && (32'(rank[i]) == k)) begin
          lane_valid[k]              = 1'b1;
          lane_idx[k*IDX_W +: IDX_W] = IDX_W'(i);
        end
      end
    end
  end

endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter int unsigned N     = 8,
  parameter int unsigned WIDTH = 2,
  localparam int unsigned IDX_W  = $clog2(N),
  localparam int unsigned FREE_W = $clog2(N + 1)
) (
  input  logic [N-1:0]           empty,
  output logic [WIDTH-1:0]       slot_ok,
  output logic [WIDTH*IDX_W-1:0] slot_idx,
  output logic [FREE_W-1:0]      free_cnt
);

  logic [FREE_W-1:0] below [N];

  // below[i] = empty entries with a lower index than i
  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < N; i++) begin
      below[i] = free_cnt;
      if (empty[i]) free_cnt = free_cnt + FREE_W'(1);
    end
  end

  for (genvar k = 0; k < WIDTH; k++) begin : g_lane
    always_comb begin
      slot_ok[k]                 = 1'b0;
      slot_idx[k*IDX_W +: IDX_W] = '0;
      for (int i = 0; i < N; i++) begin
        if (empty[i] && (32'(below[i]) == k)) begin
          slot_ok[k]                 = 1'b1;
          slot_idx[k*IDX_W +: IDX_W] = IDX_W'(i);
        end
      end
    end
  end

endmodule

// File: rtl/iq_oldest_first.sv
module iq_oldest_first #(
  parameter int unsigned IQ_SIZE  = 8,
  parameter int unsigned WIDTH    = 2,
  parameter int unsigned WK_PORTS = 2,
  parameter int unsigned TAG_W    = 6,
  parameter int unsigned SEQ_W    = 5,
  localparam int unsigned CNT_W  = $clog2(WIDTH + 1),
  localparam int unsigned FREE_W = $clog2(IQ_SIZE + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      disp_valid,
  output logic                      disp_ready,
  input  logic [CNT_W-1:0]          disp_cnt,
  input  logic [WIDTH*SEQ_W-1:0]    disp_seq,
  input  logic [WIDTH*TAG_W-1:0]    disp_tag_a,
  input  logic [WIDTH-1:0]          disp_rdy_a,
  input  logic [WIDTH*TAG_W-1:0]    disp_tag_b,
  input  logic [WIDTH-1:0]          disp_rdy_b,
  input  logic [WK_PORTS-1:0]       wk_valid,
  input  logic [WK_PORTS*TAG_W-1:0] wk_tag,
  input  logic                      iss_ready,
  output logic [WIDTH-1:0]          iss_valid,
  output logic [WIDTH*SEQ_W-1:0]    iss_seq,
  output logic [FREE_W-1:0]         free_slots
);

  localparam int unsigned IDX_W = $clog2(IQ_SIZE);

  logic [IQ_SIZE-1:0]       vld_q, rdy_a_q, rdy_b_q;
  logic [IQ_SIZE*SEQ_W-1:0] seq_q;
  logic [IQ_SIZE*TAG_W-1:0] tag_a_q, tag_b_q;

  logic [IQ_SIZE-1:0]       hit_qa, hit_qb, elig, grant;
  logic [WIDTH-1:0]         hit_ia, hit_ib, slot_ok, lane_take;
  logic [WIDTH*IDX_W-1:0]   slot_idx, lane_idx;
  logic [IDX_W-1:0]         slot_of [WIDTH];
  logic                     disp_fire;

  // wakeup matching for queued operands and for incoming operands
  iq_tag_match #(.M(IQ_SIZE), .TAG_W(TAG_W), .WK_PORTS(WK_PORTS)) u_wk_qa (
    .tags(tag_a_q), .wk_valid(wk_valid), .wk_tag(wk_tag), .hit(hit_qa));
  iq_tag_match #(.M(IQ_SIZE), .TAG_W(TAG_W), .WK_PORTS(WK_PORTS)) u_wk_qb (
    .tags(tag_b_q), .wk_valid(wk_valid), .wk_tag(wk_tag), .hit(hit_qb));
  iq_tag_match #(.M(WIDTH), .TAG_W(TAG_W), .WK_PORTS(WK_PORTS)) u_wk_ia (
    .tags(disp_tag_a), .wk_valid(wk_valid), .wk_tag(wk_tag), .hit(hit_ia));
  iq_tag_match #(.M(WIDTH), .TAG_W(TAG_W), .WK_PORTS(WK_PORTS)) u_wk_ib (
    .tags(disp_tag_b), .wk_valid(wk_valid), .wk_tag(wk_tag), .hit(hit_ib));

  assign elig = vld_q & rdy_a_q & rdy_b_q;

  iq_select #(.N(IQ_SIZE), .WIDTH(WIDTH), .SEQ_W(SEQ_W)) u_sel (
    .elig(elig), .seqs(seq_q), .grant(grant),
    .lane_valid(iss_valid), .lane_idx(lane_idx));

  iq_alloc #(.N(IQ_SIZE), .WIDTH(WIDTH)) u_alloc (
    .empty(~vld_q), .slot_ok(slot_ok), .slot_idx(slot_idx), .free_cnt(free_slots));

  assign disp_ready = (32'(disp_cnt) <= WIDTH) && (32'(disp_cnt) <= 32'(free_slots));
  assign disp_fire  = disp_valid && disp_ready;

  for (genvar k = 0; k < WIDTH; k++) begin : g_lane
    assign slot_of[k]   = slot_idx[k*IDX_W +: IDX_W];
    assign lane_take[k] = disp_fire && (32'(disp_cnt) > k) && slot_ok[k];
    assign iss_seq[k*SEQ_W +: SEQ_W] =
      seq_q[32'(lane_idx[k*IDX_W +: IDX_W])*SEQ_W +: SEQ_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      rdy_a_q <= '0;
      rdy_b_q <= '0;
      seq_q   <= '0;
      tag_a_q <= '0;
      tag_b_q <= '0;
    end else begin
      rdy_a_q <= rdy_a_q | hit_qa;
      rdy_b_q <= rdy_b_q | hit_qb;
      if (iss_ready) vld_q <= vld_q & ~grant;
      for (int k = 0; k < WIDTH; k++) begin
        if (lane_take[k]) begin
          vld_q[slot_of[k]]                      <= 1'b1;
          seq_q[32'(slot_of[k])*SEQ_W +: SEQ_W]  <= disp_seq[k*SEQ_W +: SEQ_W];
          tag_a_q[32'(slot_of[k])*TAG_W +: TAG_W] <= disp_tag_a[k*TAG_W +: TAG_W];
          tag_b_q[32'(slot_of[k])*TAG_W +: TAG_W] <= disp_tag_b[k*TAG_W +: TAG_W];
          rdy_a_q[slot_of[k]]                    <= disp_rdy_a[k] | hit_ia[k];
          rdy_b_q[slot_of[k]]                    <= disp_rdy_b[k] | hit_ib[k];
        end
      end
    end
  end

endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
  parameter int unsigned IQ_SIZE = 8,
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned SEQ_W   = 5,
  localparam int unsigned CNT_W  = $clog2(WIDTH + 1),
  localparam int unsigned FREE_W = $clog2(IQ_SIZE + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   disp_valid,
  input logic                   disp_ready,
  input logic [CNT_W-1:0]       disp_cnt,
  input logic                   iss_ready,
  input logic [WIDTH-1:0]       iss_valid,
  input logic [WIDTH*SEQ_W-1:0] iss_seq,
  input logic [FREE_W-1:0]      free_slots
);

  int acc_n, out_n;
  always_comb begin
    acc_n = (disp_valid && disp_ready) ? 32'(disp_cnt) : 0;
    out_n = iss_ready ? $countones(iss_valid) : 0;
  end

  a_r2_fit_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(disp_cnt) > 32'(free_slots)) |-> !disp_ready);

  a_r3_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> (32'(free_slots) <= IQ_SIZE));

  a_r3_free_accounting: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (32'(free_slots) == 32'($past(free_slots)) - $past(acc_n) + $past(out_n)));

  a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_ready && iss_valid[0]) |=> iss_valid[0]);

  for (genvar k = 1; k < WIDTH; k++) begin : g_ord
    logic [SEQ_W-1:0] diff;
    assign diff = iss_seq[(k-1)*SEQ_W +: SEQ_W] - iss_seq[k*SEQ_W +: SEQ_W];
    a_r5_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[k] |-> (iss_valid[k-1] && diff[SEQ_W-1]));
  end

endmodule

bind iq_oldest_first iq_checker #(.IQ_SIZE(IQ_SIZE), .WIDTH(WIDTH), .SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_cnt(disp_cnt), .iss_ready(iss_ready), .iss_valid(iss_valid),
  .iss_seq(iss_seq), .free_slots(free_slots));

// File: tb/test_iq_oldest_first.sv
module test_iq_oldest_first;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 1'b0;
  logic        disp_ready;
  logic [1:0]  disp_cnt = '0;
  logic [9:0]  disp_seq = '0;
  logic [11:0] disp_tag_a = '0, disp_tag_b = '0;
  logic [1:0]  disp_rdy_a = '0, disp_rdy_b = '0;
  logic [1:0]  wk_valid = '0;
  logic [11:0] wk_tag = '0;
  logic        iss_ready = 1'b0;
  logic [1:0]  iss_valid;
  logic [9:0]  iss_seq;
  logic [3:0]  free_slots;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  iq_oldest_first i_iq_oldest_first (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_cnt(disp_cnt), .disp_seq(disp_seq), .disp_tag_a(disp_tag_a),
    .disp_rdy_a(disp_rdy_a), .disp_tag_b(disp_tag_b), .disp_rdy_b(disp_rdy_b),
    .wk_valid(wk_valid), .wk_tag(wk_tag), .iss_ready(iss_ready),
    .iss_valid(iss_valid), .iss_seq(iss_seq), .free_slots(free_slots));

  typedef struct packed {
    logic dv; logic [1:0] dc; logic [4:0] s0, s1;
    logic [5:0] ta0; logic ra0; logic [5:0] tb0; logic rb0;
    logic [5:0] ta1; logic ra1; logic [5:0] tb1; logic rb1;
    logic wv; logic [5:0] wt; logic ir;
    logic edr; logic [3:0] efree; logic [1:0] eiv; logic [4:0] es0, es1;
  } vec_t;

  // dv dc s0 s1 | ta0 ra0 tb0 rb0 | ta1 ra1 tb1 rb1 | wv wt ir || edr free iv es0 es1
  localparam vec_t TAB [20] = '{
    '{1,2, 0, 1, 0,1,0,1, 5,0,0,1, 0,0,0, 1,8,0, 0, 0},
    '{1,2, 2, 3, 0,1,0,1, 7,0,5,0, 0,0,0, 1,6,1, 0, 0},  // R4: seq1 waits on tag5
    '{0,0, 0, 0, 0,0,0,0, 0,0,0,0, 1,5,1, 1,4,3, 0, 2},  // R7: wake tag5 seen next row
    '{1,2, 4, 5, 7,0,0,1, 0,1,0,1, 1,7,1, 1,6,1, 1, 0},  // R8: tag7 wakes incoming seq4; R4: seq3 half ready
    '{0,0, 0, 0, 0,0,0,0, 0,0,0,0, 0,0,0, 1,5,3, 3, 4},  // R9: stall
    '{0,0, 0, 0, 0,0,0,0, 0,0,0,0, 0,0,1, 1,5,3, 3, 4},
    '{0,0, 0, 0, 0,0,0,0, 0,0,0,0, 0,0,1, 1,7,1, 5, 0},
    '{0,0, 0, 0, 0,0,0,0, 0,0,0,0, 0,0,1, 1,8,0, 0, 0},
    '{1,2, 6, 7, 9,0,0,1, 9,0,0,1, 0,0,1, 1,8,0, 0, 0},
    '{1,2, 8, 9, 9,0,0,1, 9,0,0,1, 0,0,1, 1,6,0, 0, 0},
    '{1,2,10,11, 9,0,0,1, 9,0,0,1, 0,0,1, 1,4,0, 0, 0},
    '{1,2,12,13, 9,0,0,1, 9,0,0,1, 0,0,1, 1,2,0, 0, 0},
    '{1,1,14, 0, 0,1,0,1, 0,1,0,1, 0,0,1, 0,0,0, 0, 0},  // R2: full, refused
    '{1,2,14,15, 0,1,0,1, 0,1,0,1, 1,9,0, 0,0,0, 0, 0},  // R7: not yet eligible
    '{0,0, 0, 0, 0,0,0,0, 0,0,0,0, 0,0,1, 1,0,3, 6, 7},
    '{1,2,14,15, 0,1,0,1, 0,1,0,1, 0,0,1, 1,2,3, 8, 9},  // R10: new seqs in low slots
    '{0,0, 0, 0, 0,0,0,0, 0,0,0,0, 0,0,1, 1,2,3,10,11},
    '{0,0, 0, 0, 0,0,0,0, 0,0,0,0, 0,0,1, 1,4,3,12,13},
    '{0,0, 0, 0, 0,0,0,0, 0,0,0,0, 0,0,1, 1,6,3,14,15},
    '{0,0, 0, 0, 0,0,0,0, 0,0,0,0, 0,0,1, 1,8,0, 0, 0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input vec_t v);
    disp_valid = v.dv; disp_cnt = v.dc;
    disp_seq   = {v.s1, v.s0};
    disp_tag_a = {v.ta1, v.ta0}; disp_rdy_a = {v.ra1, v.ra0};
    disp_tag_b = {v.tb1, v.tb0}; disp_rdy_b = {v.rb1, v.rb0};
    wk_valid   = {1'b0, v.wv};   wk_tag = {6'd0, v.wt};
    iss_ready  = v.ir;
  endtask

  task automatic expect_out(input string tag, input vec_t v);
    chk({"R2 disp_ready ", tag}, int'(disp_ready), int'(v.edr));
    chk({"R3 free_slots ", tag}, int'(free_slots), int'(v.efree));
    chk({"R5 iss_valid ", tag}, int'(iss_valid), int'(v.eiv));
    if (v.eiv[0]) chk({"R5 lane0 seq ", tag}, int'(iss_seq[4:0]), int'(v.es0));
    if (v.eiv[1]) chk({"R5 lane1 seq ", tag}, int'(iss_seq[9:5]), int'(v.es1));
  endtask

  task automatic do_reset();
    drive('0);
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic vec_t mk(input logic dv, input logic [1:0] dc,
                              input logic [4:0] s0, input logic [4:0] s1, input logic ir);
    vec_t v = '0;
    v.dv = dv; v.dc = dc; v.s0 = s0; v.s1 = s1;
    v.ra0 = 1; v.rb0 = 1; v.ra1 = 1; v.rb1 = 1; v.ir = ir;
    return v;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    @(negedge clk);
    do_reset();
    #1;
    chk("R1 free after reset", int'(free_slots), 8);
    chk("R1 no issue after reset", int'(iss_valid), 0);

    @(negedge clk);
    for (int r = 0; r < 20; r++) begin
      drive(TAB[r]);
      #1;
      expect_out($sformatf("row%0d", r), TAB[r]);
      @(negedge clk);
    end

    // R6: wraparound age compare
    do_reset();
    @(negedge clk);
    drive(mk(1, 2, 0, 1, 0)); @(negedge clk);
    drive(mk(1, 2, 30, 31, 0)); @(negedge clk);
    drive(mk(0, 0, 0, 0, 0)); #1;
    chk("R6 wrap lane0", int'(iss_seq[4:0]), 30);
    chk("R6 wrap lane1", int'(iss_seq[9:5]), 31);
    chk("R3 four held", int'(free_slots), 4);

    // R2: zero-size bundle and oversize count
    v = mk(1, 0, 0, 0, 0); drive(v); #1;
    chk("R2 empty bundle ready", int'(disp_ready), 1);
    @(negedge clk); #1;
    chk("R2 empty bundle stores nothing", int'(free_slots), 4);
    v = mk(1, 3, 7, 8, 0); drive(v); #1;
    chk("R2 count above width refused", int'(disp_ready), 0);
    @(negedge clk); drive(mk(0, 0, 0, 0, 0)); #1;
    chk("R2 refused bundle stores nothing", int'(free_slots), 4);

    // R1: reset mid-run clears held entries
    do_reset(); #1;
    chk("R1 reset clears entries", int'(free_slots), 8);
    chk("R1 reset clears lanes", int'(iss_valid), 0);

    // R7: second completion port wakes operand b
    @(negedge clk);
    v = mk(1, 1, 3, 0, 0); v.rb0 = 0; v.tb0 = 12; drive(v); @(negedge clk);
    drive(mk(0, 0, 0, 0, 0)); wk_valid = 2'b10; wk_tag = {6'd12, 6'd0}; #1;
    chk("R7 not eligible in broadcast cycle", int'(iss_valid), 0);
    @(negedge clk); drive(mk(0, 0, 0, 0, 1)); #1;
    chk("R7 port1 wake lane valid", int'(iss_valid), 1);
    chk("R7 port1 wake seq", int'(iss_seq[4:0]), 3);
    @(negedge clk); #1;
    chk("R9 issued entry left", int'(free_slots), 8);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule